// File: doc/BRIEF.md
# Single-Wire Half-Duplex Debug Serial Port

This block moves 8-bit characters in both directions over one shared open-drain line. The line can only be pulled low or released. A byte written into the transmit holding register goes out as a frame. A frame seen on the line is captured into a receive buffer. Four sticky error flags record line faults, and a single level interrupt reports pending events. The line is wired-AND, so a far-end agent pulling low always wins. While a one is being sent, the sender therefore watches the line to detect a collision.

Two controls decide who owns the pin. The engine-connect input joins the serial engine to the pin. When it is low, the registers, flags and interrupt keep working, but nothing reaches or leaves the line. Port mode hands the pin to software: an output-enable chooses between sensing the level and driving a chosen level. An external measurement unit can pulse a strobe to report that it reloaded the baud divisor.

Transmitter states: TX_IDLE, TX_START, TX_DATA, TX_STOP. Named transitions:
- launch: TX_IDLE to TX_START, on a tick while sending is allowed.
- start_done: TX_START to TX_DATA.
- last_bit: TX_DATA to TX_STOP.
- frame_end: TX_STOP to TX_IDLE.
- abort: TX_DATA or TX_STOP to TX_IDLE, on a collision.

Receiver states: RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH. Named transitions:
- edge_seen: RX_IDLE to RX_START.
- false_start: RX_START to RX_IDLE, when the line is high at mid-start.
- start_ok: RX_START to RX_DATA.
- byte_done: RX_DATA to RX_STOP.
- stop_good: RX_STOP to RX_IDLE.
- stop_low: RX_STOP to RX_WAIT_HIGH.
- line_back: RX_WAIT_HIGH to RX_IDLE.

Top module: `swire_uart`

## Requirements
- R1: One bit lasts 16*(baud_div+1) clock cycles. A frame is a low start bit, then eight data bits least significant first, then a high stop bit. pin_drive_low=1 means the block pulls the line low.
- R2: A byte written with wr_tx is sent when sending is allowed. tx_empty returns to 1 as the frame begins. At that moment flags bit 4 (transmit-empty event) sets.
- R3: A frame received on the line loads rx_data and sets rx_full. rd_rx clears rx_full. The receiver ignores the line while the block is itself transmitting.
- R4: If the line is sampled low at mid-bit while the block sends a one, flags bit 0 (collision) sets. The frame is then abandoned and the line released.
- R5: A stop bit sampled low sets flags bit 1 (framing). The byte is still loaded and rx_full set.
- R6: A frame that completes while rx_full is 1 sets flags bit 2 (overrun). The earlier rx_data is kept.
- R7: Ten bit times of continuous low set flags bit 3 (break). Nine bit times do not set it.
- R8: No frame starts while rx_full is 1 or any of flags bits 0 to 3 is 1.
- R9: With enable=0, the line is never pulled and received frames are not captured. A written byte is still consumed, so tx_empty and flags bit 4 still set.
- R10: Writing 1 to a bit of clr_w1c clears that flag. irq is 1 exactly when rx_full, or any of flags bits 1 to 5, is 1.
- R11: With gpio_mode=1 the engine is detached. If gpio_oe=1, the line is pulled low exactly when gpio_idle=0. pin_level shows the line level two cycles late.
- R12: A pulse on ab_load sets flags bit 5 and raises irq.
- R13: After reset, tx_empty=1, rx_full=0, flags=0, irq=0, and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Oversample tick divisor |
| enable | input | 1 | Connect the serial engine to the pin |
| gpio_mode | input | 1 | Give the pin to software |
| gpio_oe | input | 1 | Port-mode output enable |
| gpio_idle | input | 1 | Port-mode level to drive |
| ab_load | input | 1 | Baud reload event strobe |
| wr_tx | input | 1 | Write strobe for the transmit register |
| wr_data | input | 8 | Byte to transmit |
| rd_rx | input | 1 | Read strobe for the receive buffer |
| clr_w1c | input | 6 | Write-one-to-clear strobes for flags |
| pin_in | input | 1 | Raw line level |
| pin_drive_low | output | 1 | Pull the line low |
| pin_level | output | 1 | Synchronised line level |
| rx_data | output | 8 | Receive buffer |
| rx_full | output | 1 | Receive buffer holds unread data |
| tx_empty | output | 1 | Transmit register free |
| flags | output | 6 | Sticky flags: 0 collision, 1 framing, 2 overrun, 3 break, 4 transmit-empty event, 5 baud reload event |
| irq | output | 1 | Interrupt level |

## Verification
The assertions assume that rst_n is held long enough to fill the synchroniser with the released level. They also assume that strobes are one clock wide and that baud_div changes only while no frame is in flight. The stimulus changes the divisor only between frames, after the line has been idle for more than a frame time. The far-end agent only ever pulls the line low or lets it go, so the line is the wired-AND that collision detection relies on. Every far-end pulse is a whole number of bit times, except the deliberate short pulse that triggers a collision.

// File: rtl/swu_pkg.sv
package swu_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH} rx_state_t;

    localparam int FLAG_W  = 6;
    localparam int F_COL   = 0;
    localparam int F_FRM   = 1;
    localparam int F_OVR   = 2;
    localparam int F_BRK   = 3;
    localparam int F_TXE   = 4;
    localparam int F_ABD   = 5;
endpackage

// File: rtl/swu_baud.sv
module swu_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= div;
        else           cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/swu_tx.sv
module swu_tx
    import swu_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic       go,
    input  logic [7:0] tx_byte,
    output logic       drive_low,
    output logic       load,
    output logic       col,
    output logic       busy
);
    localparam int PH_W = $clog2(OSR);
    localparam int HALF = OSR / 2;

    tx_state_t       state, nxt;
    logic [PH_W-1:0] ph;
    logic [2:0]      idx;
    logic [7:0]      sh;
    logic            end_bit, sending_one;

    always_comb begin
        end_bit     = tick && (ph == PH_W'(OSR - 1));
        sending_one = (state == TX_DATA && sh[0]) || (state == TX_STOP);
        col         = tick && sending_one && (ph == PH_W'(HALF - 1)) && !line;
        load        = tick && go && (state == TX_IDLE);
        nxt         = state;
        unique case (state)
            TX_IDLE:  if (load) nxt = TX_START;
            TX_START: if (end_bit) nxt = TX_DATA;
            TX_DATA: begin
                if (col)                            nxt = TX_IDLE;
                else if (end_bit && idx == 3'd7)    nxt = TX_STOP;
            end
            TX_STOP:  if (col || end_bit) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph  <= '0;
            idx <= '0;
            sh  <= '0;
        end else begin
            if (nxt != state)  ph <= '0;
            else if (end_bit)  ph <= '0;
            else if (tick)     ph <= ph + 1'b1;
            if (load) begin
                sh  <= tx_byte;
                idx <= '0;
            end else if (state == TX_DATA && end_bit) begin
                sh  <= {1'b1, sh[7:1]};
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        drive_low = (state == TX_START) || (state == TX_DATA && !sh[0]);
        busy      = (state != TX_IDLE);
    end

    // R8
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && !go) |=> (state == TX_IDLE));

    // R4
    col_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col |=> (state == TX_IDLE && !drive_low));
endmodule

// File: rtl/swu_rx.sv
module swu_rx
    import swu_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int BREAK_BITS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic       hold,
    output logic       done,
    output logic [7:0] data,
    output logic       stop_bad,
    output logic       brk_hit,
    output logic       idle
);
    localparam int PH_W      = $clog2(OSR);
    localparam int HALF      = OSR / 2;
    localparam int BRK_TICKS = OSR * BREAK_BITS;
    localparam int BRK_W     = $clog2(BRK_TICKS + 1);

    rx_state_t        state, nxt;
    logic [PH_W-1:0]  ph;
    logic [2:0]       idx;
    logic [7:0]       sh;
    logic [BRK_W-1:0] brk_cnt;
    logic             end_bit;

    always_comb begin
        end_bit = tick && (ph == PH_W'(OSR - 1));
        nxt     = state;
        unique case (state)
            RX_IDLE:      if (tick && !hold && !line) nxt = RX_START;
            RX_START:     if (tick && ph == PH_W'(HALF - 1)) nxt = line ? RX_IDLE : RX_DATA;
            RX_DATA:      if (end_bit && idx == 3'd7) nxt = RX_STOP;
            RX_STOP:      if (end_bit) nxt = line ? RX_IDLE : RX_WAIT_HIGH;
            RX_WAIT_HIGH: if (tick && line) nxt = RX_IDLE;
            default:      nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph      <= '0;
            idx     <= '0;
            sh      <= '0;
            brk_cnt <= '0;
        end else begin
            if (nxt != state)  ph <= '0;
            else if (end_bit)  ph <= '0;
            else if (tick)     ph <= ph + 1'b1;
            if (state == RX_START) idx <= '0;
            else if (state == RX_DATA && end_bit) begin
                sh  <= {line, sh[7:1]};
                idx <= idx + 1'b1;
            end
            if (hold || line) begin
                if (tick || hold) brk_cnt <= '0;
            end else if (tick && brk_cnt != BRK_W'(BRK_TICKS)) begin
                brk_cnt <= brk_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        done     = (state == RX_STOP) && end_bit;
        stop_bad = !line;
        data     = sh;
        brk_hit  = tick && !hold && !line && (brk_cnt == BRK_W'(BRK_TICKS - 1));
        idle     = (state == RX_IDLE);
    end

    // R3
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && hold) |=> (state == RX_IDLE));
endmodule

// File: rtl/swire_uart.sv
module swire_uart
    import swu_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int OSR        = 16,
    parameter int BREAK_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              enable,
    input  logic              gpio_mode,
    input  logic              gpio_oe,
    input  logic              gpio_idle,
    input  logic              ab_load,
    input  logic              wr_tx,
    input  logic [7:0]        wr_data,
    input  logic              rd_rx,
    input  logic [FLAG_W-1:0] clr_w1c,
    input  logic              pin_in,
    output logic              pin_drive_low,
    output logic              pin_level,
    output logic [7:0]        rx_data,
    output logic              rx_full,
    output logic              tx_empty,
    output logic [FLAG_W-1:0] flags,
    output logic              irq
);
    logic [1:0]        sync;
    logic              tick, eng_line, engine_on, blocked;
    logic              tx_drive, tx_load, tx_col, tx_busy;
    logic              rx_done, rx_stop_bad, rx_brk, rx_idle;
    logic [7:0]        rx_byte, tx_hold;
    logic              tx_full;
    logic [FLAG_W-1:0] set_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], pin_in};
    end

    always_comb begin
        engine_on     = enable && !gpio_mode;
        eng_line      = engine_on ? sync[1] : 1'b1;
        pin_level     = sync[1];
        pin_drive_low = gpio_mode ? (gpio_oe && !gpio_idle) : (enable && tx_drive);
        blocked       = rx_full || (|flags[F_BRK:F_COL]);
        tx_empty      = !tx_full;
        irq           = rx_full || (|flags[F_ABD:F_FRM]);
    end

    swu_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    swu_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(eng_line),
        .go(tx_full && !blocked && rx_idle), .tx_byte(tx_hold),
        .drive_low(tx_drive), .load(tx_load), .col(tx_col), .busy(tx_busy)
    );

    swu_rx #(.OSR(OSR), .BREAK_BITS(BREAK_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(eng_line), .hold(tx_busy),
        .done(rx_done), .data(rx_byte), .stop_bad(rx_stop_bad),
        .brk_hit(rx_brk), .idle(rx_idle)
    );

    always_comb begin
        set_v        = '0;
        set_v[F_COL] = tx_col;
        set_v[F_FRM] = rx_done && !(rx_full && !rd_rx) && rx_stop_bad;
        set_v[F_OVR] = rx_done && rx_full && !rd_rx;
        set_v[F_BRK] = rx_brk;
        set_v[F_TXE] = tx_load;
        set_v[F_ABD] = ab_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold <= '0;
            tx_full <= 1'b0;
            rx_data <= '0;
            rx_full <= 1'b0;
            flags   <= '0;
        end else begin
            if (wr_tx) begin
                tx_hold <= wr_data;
                tx_full <= 1'b1;
            end else if (tx_load) begin
                tx_full <= 1'b0;
            end
            if (rx_done && !(rx_full && !rd_rx)) begin
                rx_data <= rx_byte;
                rx_full <= 1'b1;
            end else if (rd_rx) begin
                rx_full <= 1'b0;
            end
            flags <= (flags & ~clr_w1c) | set_v;
            if (wr_tx && !tx_load) flags[F_TXE] <= 1'b0;
        end
    end

    // R6
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_OVR]) |-> $past(rx_full));

    // R3
    rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_rx) |=> $stable(rx_data));

    // R2
    txe_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_TXE]) |-> $past(tx_full));
endmodule

// File: tb/swire_uart_tb.sv
module swire_uart_tb;
    localparam int BT = 16;
    localparam int B_COL = 0, B_FRM = 1, B_OVR = 2, B_BRK = 3, B_TXE = 4, B_ABD = 5;

    logic        clk = 0, rst_n = 0;
    logic [15:0] baud_div = 16'd0;
    logic        enable = 1, gpio_mode = 0, gpio_oe = 0, gpio_idle = 1, ab_load = 0;
    logic        wr_tx = 0, rd_rx = 0;
    logic [7:0]  wr_data = 0;
    logic [5:0]  clr_w1c = 0;
    logic        agent_low = 0;
    logic        line;
    logic        pin_drive_low, pin_level, rx_full, tx_empty, irq;
    logic [7:0]  rx_data;
    logic [5:0]  flags;
    int          checks = 0, errors = 0, cyc = 0;
    bit          done_run = 0;

    assign line = !(pin_drive_low || agent_low);

    swire_uart u_dut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .enable(enable),
        .gpio_mode(gpio_mode), .gpio_oe(gpio_oe), .gpio_idle(gpio_idle),
        .ab_load(ab_load), .wr_tx(wr_tx), .wr_data(wr_data), .rd_rx(rd_rx),
        .clr_w1c(clr_w1c), .pin_in(line), .pin_drive_low(pin_drive_low),
        .pin_level(pin_level), .rx_data(rx_data), .rx_full(rx_full),
        .tx_empty(tx_empty), .flags(flags), .irq(irq)
    );

    always #5 clk = !clk;

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL R13 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] b);
        wr_data = b; wr_tx = 1; step(1); wr_tx = 0;
    endtask

    task automatic rd();
        rd_rx = 1; step(1); rd_rx = 0;
    endtask

    task automatic clr(input logic [5:0] m);
        clr_w1c = m; step(1); clr_w1c = 0;
    endtask

    task automatic send_frame(input logic [7:0] b, input bit stop_hi);
        agent_low = 1; step(BT);
        for (int i = 0; i < 8; i++) begin
            agent_low = !b[i]; step(BT);
        end
        agent_low = !stop_hi; step(BT);
        agent_low = 0;
    endtask

    task automatic wait_drive(input int lim, output bit seen);
        seen = 0;
        for (int i = 0; i < lim && !seen; i++) begin
            @(negedge clk);
            if (pin_drive_low) seen = 1;
        end
    endtask

    task automatic quiet(input int n, output bit pulled);
        pulled = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin_drive_low) pulled = 1;
        end
    endtask

    initial begin
        bit seen, pulled;
        logic [7:0] rxv [6]  = '{8'h00, 8'h55, 8'hA3, 8'hFF, 8'h80, 8'h01};
        logic [7:0] txv [5]  = '{8'h00, 8'hA5, 8'h3C, 8'hFF, 8'h81};
        int cnt;

        step(5); rst_n = 1; step(3);
        @(negedge clk);
        chk("R13 tx_empty", tx_empty, 1);
        chk("R13 rx_full", rx_full, 0);
        chk("R13 flags", flags, 0);
        chk("R13 irq", irq, 0);
        chk("R13 drive", pin_drive_low, 0);
        step(1);

        foreach (rxv[k]) begin
            send_frame(rxv[k], 1); step(20);
            @(negedge clk);
            chk("R3 rx_full", rx_full, 1);
            chk("R3 rx_data", rx_data, rxv[k]);
            chk("R5 no framing", flags[B_FRM], 0);
            chk("R10 irq on full", irq, 1);
            step(1); rd(); @(negedge clk);
            chk("R3 read clears", rx_full, 0);
            step(1);
        end

        foreach (txv[k]) begin
            wr(txv[k]);
            wait_drive(40, seen);
            chk("R2 frame starts", seen, 1);
            chk("R2 tx_empty", tx_empty, 1);
            repeat (1) @(negedge clk);
            chk("R2 txe flag", flags[B_TXE], 1);
            repeat (7) @(negedge clk);
            for (int i = 0; i < 10; i++) begin
                logic expb;
                expb = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : txv[k][i-1];
                chk("R1 tx bit", !pin_drive_low, expb);
                if (i < 9) repeat (BT) @(negedge clk);
            end
            step(20);
            chk("R3 no echo", rx_full, 0);
            clr(6'h10);
        end

        baud_div = 16'd2; step(4);
        wr(8'hFF);
        wait_drive(40, seen);
        cnt = 1;
        while (pin_drive_low && cnt < 500) begin
            @(negedge clk);
            if (pin_drive_low) cnt++;
        end
        chk("R1 divided start bit", cnt, 48);
        step(10 * 48 + 10);
        baud_div = 16'd0; step(4);
        clr(6'h3F);

        wr(8'hFF);
        wait_drive(40, seen);
        step(18); agent_low = 1; step(10); agent_low = 0; step(30);
        @(negedge clk);
        chk("R4 collision flag", flags[B_COL], 1);
        chk("R4 released", pin_drive_low, 0);
        chk("R4 byte consumed", tx_empty, 1);
        chk("R3 no spurious rx", rx_full, 0);
        step(1);

        wr(8'h3C);
        quiet(200, pulled);
        chk("R8 blocked by collision", pulled, 0);
        chk("R8 still pending", tx_empty, 0);
        step(1); clr(6'h01);
        wait_drive(40, seen);
        chk("R8 resumes", seen, 1);
        step(180); clr(6'h10);

        send_frame(8'h11, 1); step(20);
        wr(8'h22);
        quiet(200, pulled);
        chk("R8 blocked by rx_full", pulled, 0);
        step(1); rd();
        wait_drive(40, seen);
        chk("R8 resumes after read", seen, 1);
        step(180); clr(6'h10);

        send_frame(8'h5A, 0); step(20);
        @(negedge clk);
        chk("R5 framing flag", flags[B_FRM], 1);
        chk("R5 rx_full", rx_full, 1);
        chk("R5 rx_data", rx_data, 8'h5A);
        chk("R7 no break", flags[B_BRK], 0);
        step(1); rd(); clr(6'h3F);

        send_frame(8'h12, 1); send_frame(8'h34, 1); step(20);
        @(negedge clk);
        chk("R6 overrun flag", flags[B_OVR], 1);
        chk("R6 old data kept", rx_data, 8'h12);
        step(1); rd(); clr(6'h3F);

        agent_low = 1; step(9 * BT); agent_low = 0; step(40);
        @(negedge clk);
        chk("R7 nine low bits", flags[B_BRK], 0);
        chk("R7 nine low framing", flags[B_FRM], 0);
        chk("R7 nine low data", rx_data, 8'h00);
        step(1); rd();
        agent_low = 1; step(10 * BT); agent_low = 0; step(40);
        @(negedge clk);
        chk("R7 ten low bits", flags[B_BRK], 1);
        chk("R5 ten low framing", flags[B_FRM], 1);
        step(1); rd(); clr(6'h3F);
        @(negedge clk);
        chk("R10 cleared irq", irq, 0);
        chk("R10 cleared flags", flags, 0);
        step(1);

        enable = 0;
        send_frame(8'h77, 1); step(20);
        @(negedge clk);
        chk("R9 no capture", rx_full, 0);
        step(1); wr(8'h0F);
        quiet(200, pulled);
        chk("R9 line untouched", pulled, 0);
        chk("R9 consumed", tx_empty, 1);
        chk("R9 txe flag", flags[B_TXE], 1);
        chk("R9 irq", irq, 1);
        step(1); enable = 1; clr(6'h3F);

        ab_load = 1; step(1); ab_load = 0;
        @(negedge clk);
        chk("R12 reload flag", flags[B_ABD], 1);
        chk("R12 irq", irq, 1);
        step(1); clr(6'h20);
        @(negedge clk);
        chk("R10 w1c reload", irq, 0);
        step(1);

        gpio_mode = 1; gpio_oe = 1; gpio_idle = 0; step(1);
        @(negedge clk);
        chk("R11 drive low", pin_drive_low, 1);
        step(1); gpio_idle = 1; step(1);
        @(negedge clk);
        chk("R11 drive high", pin_drive_low, 0);
        step(1); gpio_oe = 0; agent_low = 1; step(3);
        @(negedge clk);
        chk("R11 sense low", pin_level, 0);
        step(1); agent_low = 0; step(3);
        @(negedge clk);
        chk("R11 sense high", pin_level, 1);
        step(1);
        send_frame(8'h66, 1); step(20);
        @(negedge clk);
        chk("R11 engine detached", rx_full, 0);

        finish_run();
    end
endmodule